// File: doc/BRIEF.md
# Per-Channel Alarm Interrupt Register Bank

This block watches two kinds of line alarm, loss of signal and output driver fault, across a set of line channels. Both alarm vectors arrive already qualified. The block presents them to a host processor through a small parallel register interface. Each alarm input first passes through a synchronizer. The block keeps the live status of each alarm and records every change of state, rising or falling, in a sticky interrupt status bit. Per-channel enable masks decide which of those sticky bits drive the single interrupt line.

When the host reads an interrupt status register, that one read returns the recorded bits and clears all of them. If an alarm changes in the same cycle as that clearing read, the change is kept. The bank also holds one software reset bit per channel. Each bit drives its channel's reset line, and it stays set until the host writes it back to zero.

Top module: `alarm_irq_bank`

## Requirements
- R1: After the asynchronous reset, every register reads zero, `irq_o` is low and `chan_rst_o` is all zero.
- R2: The register at 0x04 returns the live loss-of-signal status and 0x05 returns the live driver-fault status, with bit n for channel n. A change on an alarm input appears there SYNC_STAGES clock edges later.
- R3: When a channel's synchronized alarm changes state in either direction, the matching interrupt status bit is set: 0x08 for loss of signal, 0x09 for driver fault. The bit stays set until it is cleared.
- R4: A read of 0x08 or 0x09 returns the bits as they were before the read and clears all bits of that register.
- R5: If a change event and a clearing read of the same register fall on the same clock edge, the event's bit is left set after the read.
- R6: The enable registers are read/write: 0x06 for loss of signal and 0x07 for driver fault. `irq_o` is high exactly while some interrupt status bit is 1 and its enable bit is 1. It is low whenever both enable registers are zero.
- R7: Bit n of the read/write register at 0x0A drives `chan_rst_o[n]`. The bit holds its value until the host writes it again, so writing 0 releases the channel.
- R8: A read of an unmapped address returns zero. Writes to unmapped addresses, and writes to the read-only registers 0x04, 0x05, 0x08 and 0x09, change nothing.
- R9: Read data is registered. `rdata_o` carries the addressed register on the edge after a cycle with `rd_i` high, and it is zero after a cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| los_i | input | NUM_CH | Qualified loss-of-signal alarms, one per channel |
| flt_i | input | NUM_CH | Qualified driver-fault alarms, one per channel |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| addr_i | input | ADDR_W | Host register address |
| wdata_i | input | NUM_CH | Host write data |
| rdata_o | output | NUM_CH | Registered read data |
| irq_o | output | 1 | Interrupt, active high |
| chan_rst_o | output | NUM_CH | Software reset line per channel |

## Verification
The bench builds the block with its defaults: eight channels, an 8-bit address and a two-stage synchronizer. With a two-stage synchronizer, an alarm edge reaches the status register on a known edge. The bench can therefore place a clearing read exactly on the edge where a change event lands, which exercises the event-wins rule. Eight channels keep the first and last bit positions in reach, so masking is checked with one channel enabled and another disabled.

// File: rtl/alarm_pkg.sv
package alarm_pkg;
  localparam int NUM_ALARM = 2;
  localparam int IDX_LOS   = 0;
  localparam int IDX_FLT   = 1;

  localparam int ADR_LOS_ST  = 'h04;
  localparam int ADR_FLT_ST  = 'h05;
  localparam int ADR_LOS_EN  = 'h06;
  localparam int ADR_FLT_EN  = 'h07;
  localparam int ADR_LOS_INT = 'h08;
  localparam int ADR_FLT_INT = 'h09;
  localparam int ADR_CH_RST  = 'h0A;
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o,
  output logic [N-1:0] nxt_o
);
  logic [STAGES-1:0][N-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pipe_q <= '0;
    else begin
      pipe_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) pipe_q[k] <= pipe_q[k-1];
    end
  end

  assign q_o   = pipe_q[STAGES-1];
  assign nxt_o = pipe_q[STAGES-2];
endmodule

// File: rtl/alarm_track.sv
module alarm_track #(
  parameter int N      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alarm_i,
  input  logic         clr_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] int_o
);
  logic [N-1:0] nxt, ev, int_q;

  alarm_sync #(.N(N), .STAGES(STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (alarm_i),
    .q_o   (status_o),
    .nxt_o (nxt)
  );

  // status changes on the next edge wherever nxt differs
  assign ev = nxt ^ status_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= '0;
    else         int_q <= (clr_i ? '0 : int_q) | ev;
  end

  assign int_o = int_q;

  // R3 / R5: every event leaves its bit set, clear or not
  a_r3_event_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ev) |=> ((int_o & $past(ev)) == $past(ev)));
  // R3: without a clear, set bits stay set
  a_r3_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i) |=> ((int_o & $past(int_o)) == $past(int_o)));
  // R4: a clear with no event empties the register
  a_r4_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && ev == '0) |=> (int_o == '0));
endmodule

// File: rtl/host_regs.sv
module host_regs
  import alarm_pkg::*;
#(
  parameter int N      = 8,
  parameter int ADDR_W = 8
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic                           rd_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [N-1:0]                   wdata_i,
  input  logic [NUM_ALARM-1:0][N-1:0]    status_i,
  input  logic [NUM_ALARM-1:0][N-1:0]    int_i,
  output logic [NUM_ALARM-1:0][N-1:0]    en_o,
  output logic [NUM_ALARM-1:0]           clr_o,
  output logic [N-1:0]                   rst_o,
  output logic [N-1:0]                   rdata_o
);
  localparam logic [ADDR_W-1:0] A_LOS_ST  = ADDR_W'(ADR_LOS_ST);
  localparam logic [ADDR_W-1:0] A_FLT_ST  = ADDR_W'(ADR_FLT_ST);
  localparam logic [ADDR_W-1:0] A_LOS_EN  = ADDR_W'(ADR_LOS_EN);
  localparam logic [ADDR_W-1:0] A_FLT_EN  = ADDR_W'(ADR_FLT_EN);
  localparam logic [ADDR_W-1:0] A_LOS_INT = ADDR_W'(ADR_LOS_INT);
  localparam logic [ADDR_W-1:0] A_FLT_INT = ADDR_W'(ADR_FLT_INT);
  localparam logic [ADDR_W-1:0] A_CH_RST  = ADDR_W'(ADR_CH_RST);

  logic [NUM_ALARM-1:0][N-1:0] en_q;
  logic [N-1:0] rst_q, rdata_q, rmux;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      rst_q <= '0;
    end else if (wr_i) begin
      if (addr_i == A_LOS_EN) en_q[IDX_LOS] <= wdata_i;
      if (addr_i == A_FLT_EN) en_q[IDX_FLT] <= wdata_i;
      if (addr_i == A_CH_RST) rst_q         <= wdata_i;
    end
  end

  always_comb begin
    rmux = '0;
    unique case (addr_i)
      A_LOS_ST:  rmux = status_i[IDX_LOS];
      A_FLT_ST:  rmux = status_i[IDX_FLT];
      A_LOS_EN:  rmux = en_q[IDX_LOS];
      A_FLT_EN:  rmux = en_q[IDX_FLT];
      A_LOS_INT: rmux = int_i[IDX_LOS];
      A_FLT_INT: rmux = int_i[IDX_FLT];
      A_CH_RST:  rmux = rst_q;
      default:   rmux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_i ? rmux : '0;
  end

  assign clr_o[IDX_LOS] = rd_i && (addr_i == A_LOS_INT);
  assign clr_o[IDX_FLT] = rd_i && (addr_i == A_FLT_INT);
  assign en_o    = en_q;
  assign rst_o   = rst_q;
  assign rdata_o = rdata_q;

  // R7: reset bits move only on a write to their register
  a_r7_rst_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_CH_RST) |=> $stable(rst_o));
  // R8: enables move only on a write to their own address
  a_r8_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_LOS_EN || addr_i == A_FLT_EN)) |=> $stable(en_o));
  // R9: no read, no data
  a_r9_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == '0));
endmodule

// File: rtl/alarm_irq_bank.sv
module alarm_irq_bank
  import alarm_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] los_i,
  input  logic [NUM_CH-1:0] flt_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NUM_CH-1:0] wdata_i,
  output logic [NUM_CH-1:0] rdata_o,
  output logic              irq_o,
  output logic [NUM_CH-1:0] chan_rst_o
);
  logic [NUM_ALARM-1:0][NUM_CH-1:0] alarm_in, status, int_st, en;
  logic [NUM_ALARM-1:0]             clr;
  logic [NUM_ALARM-1:0]             irq_src;

  assign alarm_in[IDX_LOS] = los_i;
  assign alarm_in[IDX_FLT] = flt_i;

  for (genvar g = 0; g < NUM_ALARM; g++) begin : g_alarm
    alarm_track #(.N(NUM_CH), .STAGES(SYNC_STAGES)) u_track (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .alarm_i (alarm_in[g]),
      .clr_i   (clr[g]),
      .status_o(status[g]),
      .int_o   (int_st[g])
    );
    assign irq_src[g] = |(int_st[g] & en[g]);
  end

  host_regs #(.N(NUM_CH), .ADDR_W(ADDR_W)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .rd_i    (rd_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .status_i(status),
    .int_i   (int_st),
    .en_o    (en),
    .clr_o   (clr),
    .rst_o   (chan_rst_o),
    .rdata_o (rdata_o)
  );

  assign irq_o = |irq_src;

  // R6: with every enable zero the line stays quiet
  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en == '0) |-> !irq_o);
  // R6: no pending interrupt, no line
  a_r6_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_st == '0) |-> !irq_o);
endmodule

// File: tb/alarm_irq_bank_test.sv
module alarm_irq_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int AW = 8;
  localparam int NV = 14;

  // {is_write, addr, data/expected}
  localparam logic [16:0] VEC [NV] = '{
    {1'b1, 8'h06, 8'hA5}, {1'b0, 8'h06, 8'hA5},
    {1'b1, 8'h07, 8'h3C}, {1'b0, 8'h07, 8'h3C},
    {1'b1, 8'h0A, 8'h81}, {1'b0, 8'h0A, 8'h81},
    {1'b1, 8'h04, 8'hFF}, {1'b0, 8'h04, 8'h00},
    {1'b1, 8'h08, 8'hFF}, {1'b0, 8'h08, 8'h00},
    {1'b1, 8'h0F, 8'hFF}, {1'b0, 8'h0F, 8'h00},
    {1'b0, 8'h00, 8'h00}, {1'b0, 8'h06, 8'hA5}
  };

  logic clk = 0, rst_n = 0, wr = 0, rd = 0, irq;
  logic [N-1:0] los = '0, flt = '0, wdata = '0, rdata, chan_rst;
  logic [AW-1:0] addr = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alarm_irq_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .los_i(los), .flt_i(flt),
    .wr_i(wr), .rd_i(rd), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .chan_rst_o(chan_rst)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(posedge clk); @(negedge clk); wr = 0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, output logic [N-1:0] d);
    @(negedge clk); rd = 1; addr = a;
    @(posedge clk); @(negedge clk); rd = 0; d = rdata;
  endtask

  task automatic settle();
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic string tag_of(input logic [7:0] a);
    case (a)
      8'h06, 8'h07: return "R6";
      8'h0A:        return "R7";
      default:      return "R8";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset state
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 chan_rst", chan_rst, 8'h00);
    for (int a = 4; a <= 10; a++) begin
      bus_read(AW'(a), d);
      check("R1 reg", d, 8'h00);
    end
    @(negedge clk);
    check("R9 idle rdata", rdata, 8'h00);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][16]) bus_write(VEC[i][15:8], VEC[i][7:0]);
      else begin
        bus_read(VEC[i][15:8], d);
        check(tag_of(VEC[i][15:8]), d, VEC[i][7:0]);
      end
    end
    check("R7 lines", chan_rst, 8'h81);

    // LOS rising on channel 0 with enables off
    bus_write(8'h06, 8'h00);
    bus_write(8'h07, 8'h00);
    los = 8'h01;
    settle();
    bus_read(8'h04, d); check("R2 los status", d, 8'h01);
    check("R6 masked", {7'b0, irq}, 8'h00);
    bus_read(8'h08, d); check("R3 rising", d, 8'h01);
    bus_read(8'h08, d); check("R4 cleared", d, 8'h00);

    // falling edge also records
    los = 8'h00;
    settle();
    bus_read(8'h04, d); check("R2 los low", d, 8'h00);
    bus_write(8'h06, 8'h01);
    check("R6 irq on enable", {7'b0, irq}, 8'h01);
    bus_read(8'h08, d); check("R3 falling", d, 8'h01);
    check("R4 irq dropped", {7'b0, irq}, 8'h00);

    // fault on channel 7, masked then enabled
    bus_write(8'h07, 8'h3C);
    flt = 8'h80;
    settle();
    check("R6 other bits masked", {7'b0, irq}, 8'h00);
    bus_write(8'h07, 8'h80);
    check("R6 irq fault", {7'b0, irq}, 8'h01);
    bus_read(8'h05, d); check("R2 flt status", d, 8'h80);
    bus_read(8'h09, d); check("R3 flt int", d, 8'h80);

    // R5: event on the same edge as the clearing read
    @(negedge clk); flt = 8'h00;
    @(posedge clk);
    bus_read(8'h09, d); check("R5 pre-clear value", d, 8'h00);
    bus_read(8'h09, d); check("R5 event kept", d, 8'h80);
    bus_read(8'h09, d); check("R4 after keep", d, 8'h00);

    // R7: hold and release
    bus_write(8'h0A, 8'h10);
    repeat (5) @(negedge clk);
    check("R7 held", chan_rst, 8'h10);
    bus_write(8'h0B, 8'h00);
    check("R8 unmapped write", chan_rst, 8'h10);
    bus_write(8'h0A, 8'h00);
    check("R7 released", chan_rst, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule